// File: doc/BRIEF.md
# Programmable Card Clock Generator

This block derives the clock for an SD card bus from the master clock. A single control register, written through a simple write port and always readable, selects the division ratio. The ratio is a power of two from 1 to 1024. The register also holds an enable bit and an automatic-stop bit. The automatic-stop bit halts the card clock whenever the host core reports that the bus is idle.

The block produces no derived clock net. It gives two outputs instead: a one-cycle strobe that marks each rising edge of the card clock, and a registered level that follows the card clock waveform. Downstream logic clocks on the master clock and uses the strobe as its enable. The pad logic drives the level out.

Stopping never cuts a high phase short. Once the clock is running again, it always starts with a full period. The ratio is captured only when the clock starts, so changing the divisor while the clock runs cannot distort a period.

Top module: `cardclk_gen`

## Requirements
- R1: Divisor bits 0 through 7 select ratios 4, 8, 16, 32, 64, 128, 256 and 512 (bit i gives 2^(i+2)). One strobe pulse occurs every ratio cycles. The level is high for the first ratio/2 cycles of each period, starting with the strobe cycle.
- R2: When none of bits 0–7, 10 or 16 is set, the ratio is 2.
- R3: Bit 10 alone selects ratio 1. The strobe is high on every cycle and the level stays low.
- R4: Bit 16 selects ratio 1024 when parameter VERSION is 0x10 or more. Below that version, bit 16 is not stored, reads back 0 and has no effect on the ratio.
- R5: When several divisor bits are set, the one with the largest ratio wins: bit 16 (where supported), then bit 7 down to bit 0, then bit 10.
- R6: Read-back returns the stored value of bits 0–10 and 16. All other bits read 0. After reset the whole register reads 0.
- R7: Bit 8 enables the clock. While the bit is 0 and the clock is stopped, no strobe occurs. Clearing the bit lets the current period finish, so the last high phase still lasts ratio/2 cycles and the clock comes to rest low.
- R8: Bit 9 set together with core_idle high stops the clock in the same clean way as clearing bit 8. With bit 9 clear, core_idle has no effect.
- R9: The ratio is captured when the clock starts. A divisor write made while the clock runs takes effect only after the clock has stopped and started again.
- R10: After a write that starts a stopped clock, the first strobe appears on the second master clock edge after the write edge. That first period is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write value |
| core_idle | input | 1 | Host core reports the bus is unused |
| sck_rise | output | 1 | One-cycle strobe at each card clock rising edge |
| sck_lvl | output | 1 | Card clock level (stays low at ratio 1) |
| rd_data | output | REG_W | Register read-back |

## Verification
The hardest case to reach is an enable that drops in the middle of a high phase: the stop must wait for the end of the period and must not cut the pulse short. The bench clears the enable on the very cycle it sees a strobe. It then counts the remaining high cycles and confirms that no further strobe appears. The version gate needs a second instance built below the threshold version. The test for a write made while the clock runs keeps the clock going across the divisor write, then measures the period before and after a stop and restart.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
   localparam int unsigned ONEHOT_N      = 8;
   localparam int unsigned ONEHOT_LOG0   = 2;
   localparam int unsigned FLD_EN        = 8;
   localparam int unsigned FLD_AUTO      = 9;
   localparam int unsigned FLD_DIV1      = 10;
   localparam int unsigned FLD_DIV1024   = 16;
   localparam int unsigned LOG_MAX       = 10;
   localparam int unsigned LOG_W         = 4;

   typedef logic [LOG_W-1:0] ratio_log_t;

   typedef struct packed {
      logic                div1024;
      logic                div1;
      logic                auto_off;
      logic                en;
      logic [ONEHOT_N-1:0] onehot;
   } ctl_t;
endpackage

// File: rtl/cardclk_ctrl_reg.sv
module cardclk_ctrl_reg
   import cardclk_pkg::*;
#(
   parameter int unsigned REG_W        = 32,
   parameter logic [7:0]  VERSION      = 8'h10,
   parameter logic [7:0]  MIN_VER_1024 = 8'h10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output ctl_t             ctl,
   output logic [REG_W-1:0] rd_data
);
   localparam bit HAS_1024 = (VERSION >= MIN_VER_1024);

   logic [ONEHOT_N-1:0] onehot_q;
   logic                en_q, auto_q, div1_q, d1024_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         onehot_q <= '0;
         en_q     <= 1'b0;
         auto_q   <= 1'b0;
         div1_q   <= 1'b0;
      end else if (wr_en) begin
         onehot_q <= wr_data[ONEHOT_N-1:0];
         en_q     <= wr_data[FLD_EN];
         auto_q   <= wr_data[FLD_AUTO];
         div1_q   <= wr_data[FLD_DIV1];
      end
   end

   generate
      if (HAS_1024) begin : g_div1024
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     d1024_q <= 1'b0;
            else if (wr_en) d1024_q <= wr_data[FLD_DIV1024];
         end
      end else begin : g_no_div1024
         assign d1024_q = 1'b0;
      end
   endgenerate

   assign ctl = '{div1024: d1024_q, div1: div1_q, auto_off: auto_q,
                  en: en_q, onehot: onehot_q};

   always_comb begin
      rd_data                 = '0;
      rd_data[ONEHOT_N-1:0]   = onehot_q;
      rd_data[FLD_EN]         = en_q;
      rd_data[FLD_AUTO]       = auto_q;
      rd_data[FLD_DIV1]       = div1_q;
      rd_data[FLD_DIV1024]    = d1024_q;
   end

   // R6: a written value reads back on the implemented low field
   assert_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[FLD_DIV1:0] == $past(wr_data[FLD_DIV1:0]));
endmodule

// File: rtl/cardclk_ratio_dec.sv
module cardclk_ratio_dec
   import cardclk_pkg::*;
(
   input  ctl_t       ctl,
   output ratio_log_t ratio_log
);
   ratio_log_t cand [ONEHOT_N+1];

   assign cand[0] = ctl.div1 ? ratio_log_t'(0) : ratio_log_t'(1);

   generate
      for (genvar i = 0; i < ONEHOT_N; i++) begin : g_bit
         assign cand[i+1] = ctl.onehot[i] ? ratio_log_t'(i + ONEHOT_LOG0) : cand[i];
      end
   endgenerate

   assign ratio_log = ctl.div1024 ? ratio_log_t'(LOG_MAX) : cand[ONEHOT_N];
endmodule

// File: rtl/cardclk_divider.sv
module cardclk_divider
   import cardclk_pkg::*;
#(
   parameter int unsigned CNT_W = LOG_MAX
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  ratio_log_t ratio_log,
   output logic       sck_rise,
   output logic       sck_lvl
);
   logic             active_q;
   logic [CNT_W-1:0] cnt_q;
   ratio_log_t       shift_q;
   logic [CNT_W:0]   span_c;
   logic [CNT_W-1:0] last_c, half_c;

   assign span_c = (CNT_W+1)'(1) << shift_q;
   assign last_c = CNT_W'(span_c - 1'b1);
   assign half_c = CNT_W'(span_c >> 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         shift_q  <= ratio_log_t'(1);
      end else if (!active_q) begin
         if (run) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            shift_q  <= ratio_log;
         end
      end else if (cnt_q == last_c) begin
         cnt_q <= '0;
         if (!run) active_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign sck_rise = active_q && (cnt_q == '0);
   assign sck_lvl  = active_q && (cnt_q < half_c);

   // R7: the clock only comes to rest from a low phase
   assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_q) |-> $past(!sck_lvl));
   // R8: with the run request withdrawn no new edge can begin
   assert_off_no_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sck_rise);
   // R9: captured ratio holds while running
   assert_ratio_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && $past(active_q)) |-> $stable(shift_q));
   // R10: a start always opens with a rising edge
   assert_start_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_q) |-> sck_rise);
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
   import cardclk_pkg::*;
#(
   parameter int unsigned REG_W        = 32,
   parameter logic [7:0]  VERSION      = 8'h10,
   parameter logic [7:0]  MIN_VER_1024 = 8'h10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             core_idle,
   output logic             sck_rise,
   output logic             sck_lvl,
   output logic [REG_W-1:0] rd_data
);
   generate
      if (REG_W <= FLD_DIV1024) begin : g_bad_width
         $error("REG_W must hold the highest control field");
      end
   endgenerate

   ctl_t       ctl;
   ratio_log_t ratio_log;
   logic       run;

   cardclk_ctrl_reg #(.REG_W(REG_W), .VERSION(VERSION),
                      .MIN_VER_1024(MIN_VER_1024)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .ctl(ctl), .rd_data(rd_data));

   cardclk_ratio_dec u_dec (.ctl(ctl), .ratio_log(ratio_log));

   assign run = ctl.en && !(ctl.auto_off && core_idle);

   cardclk_divider #(.CNT_W(LOG_MAX)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run), .ratio_log(ratio_log),
      .sck_rise(sck_rise), .sck_lvl(sck_lvl));

   // R3: at ratio 1 the level never rises
   assert_div1_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_rise && $past(sck_rise) && $past(sck_rise, 2)) |-> !sck_lvl);
endmodule

// File: tb/cardclk_gen_tb.sv
module cardclk_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int REG_W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [REG_W-1:0] wr_data = '0;
   logic core_idle = 1'b0;
   logic rise_n, lvl_n, rise_o, lvl_o;
   logic [REG_W-1:0] rd_n, rd_o;
   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cardclk_gen #(.REG_W(REG_W), .VERSION(8'h10)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .core_idle(core_idle), .sck_rise(rise_n), .sck_lvl(lvl_n), .rd_data(rd_n));

   cardclk_gen #(.REG_W(REG_W), .VERSION(8'h0F)) u_old (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .core_idle(core_idle), .sck_rise(rise_o), .sck_lvl(lvl_o), .rd_data(rd_o));

   localparam logic [REG_W-1:0] EN   = 32'h0000_0100;
   localparam logic [REG_W-1:0] AUTO = 32'h0000_0200;
   localparam logic [REG_W-1:0] D1   = 32'h0000_0400;
   localparam logic [REG_W-1:0] D1K  = 32'h0001_0000;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [REG_W-1:0] v);
      wr_data = v; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic get_rise(input bit old);
      return old ? rise_o : rise_n;
   endfunction
   function automatic logic get_lvl(input bit old);
      return old ? lvl_o : lvl_n;
   endfunction

   // measures one full period: cycles between strobes and high cycles in it
   task automatic measure(input bit old, output int per, output int hi);
      int guard = 0;
      per = 0; hi = 0;
      while (!get_rise(old) && guard < 3000) begin @(negedge clk); guard++; end
      do begin
         hi += get_lvl(old);
         per++;
         @(negedge clk);
      end while (!get_rise(old) && per < 3000);
   endtask

   task automatic stop_all();
      wr('0);
      idle(1100);
   endtask

   task automatic t_reset();
      chk("R6 reset readback", int'(rd_n), 0);
      chk("R7 reset strobe", int'(rise_n), 0);
      chk("R7 reset level", int'(lvl_n), 0);
   endtask

   task automatic t_onehot();
      int per, hi;
      for (int b = 0; b < 8; b++) begin
         wr(EN | (32'h1 << b));
         measure(1'b0, per, hi);
         chk($sformatf("R1 period bit%0d", b), per, 1 << (b + 2));
         chk($sformatf("R1 high bit%0d", b), hi, 1 << (b + 1));
         wr('0);
         idle((1 << (b + 2)) + 4);
      end
   endtask

   task automatic t_div2_div1();
      int per, hi, cnt;
      wr(EN);
      measure(1'b0, per, hi);
      chk("R2 period", per, 2);
      chk("R2 high", hi, 1);
      stop_all();
      wr(EN | D1);
      cnt = 0; hi = 0;
      idle(1);
      for (int i = 0; i < 20; i++) begin cnt += rise_n; hi += lvl_n; @(negedge clk); end
      chk("R3 strobes in 20", cnt, 20);
      chk("R3 level high count", hi, 0);
      stop_all();
   endtask

   task automatic t_div1024();
      int per, hi;
      wr(EN | D1K);
      measure(1'b0, per, hi);
      chk("R4 period 1024", per, 1024);
      chk("R4 high 1024", hi, 512);
      stop_all();
      wr(EN | D1K);
      chk("R4 old readback bit16", int'(rd_o[16]), 0);
      measure(1'b1, per, hi);
      chk("R4 old ignores bit16", per, 2);
      stop_all();
   endtask

   task automatic t_priority();
      int per, hi;
      wr(EN | 32'h9);
      measure(1'b0, per, hi);
      chk("R5 bits0+3", per, 32);
      stop_all();
      wr(EN | D1K | 32'h1);
      measure(1'b0, per, hi);
      chk("R5 bit16+bit0", per, 1024);
      stop_all();
      wr(EN | D1 | 32'h2);
      measure(1'b0, per, hi);
      chk("R5 bit10+bit1", per, 8);
      stop_all();
   endtask

   task automatic t_readback();
      wr('1);
      chk("R6 readback all ones", int'(rd_n), 32'h0001_07FF);
      chk("R6 old readback all ones", int'(rd_o), 32'h0000_07FF);
      stop_all();
   endtask

   task automatic t_stop_midhigh();
      int hi, rises, guard;
      wr(EN | 32'h2);
      guard = 0;
      while (!rise_n && guard < 100) begin @(negedge clk); guard++; end
      hi = 1; rises = 0;
      wr_data = '0; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      for (int i = 0; i < 40; i++) begin hi += lvl_n; rises += rise_n; @(negedge clk); end
      chk("R7 last high full", hi, 4);
      chk("R7 no strobe after stop", rises, 0);
      chk("R7 rests low", int'(lvl_n), 0);
   endtask

   task automatic t_auto_off();
      int per, hi, rises;
      core_idle = 1'b1;
      wr(EN | AUTO | 32'h1);
      rises = 0;
      for (int i = 0; i < 20; i++) begin rises += rise_n; @(negedge clk); end
      chk("R8 idle holds clock", rises, 0);
      core_idle = 1'b0;
      measure(1'b0, per, hi);
      chk("R8 runs when busy", per, 4);
      core_idle = 1'b1;
      idle(8);
      rises = 0;
      for (int i = 0; i < 20; i++) begin rises += rise_n; @(negedge clk); end
      chk("R8 idle stops clock", rises, 0);
      wr(EN | 32'h1);
      measure(1'b0, per, hi);
      chk("R8 idle ignored without auto", per, 4);
      core_idle = 1'b0;
      stop_all();
   endtask

   task automatic t_change_running();
      int per, hi;
      wr(EN | 32'h1);
      measure(1'b0, per, hi);
      wr(EN | 32'h8);
      measure(1'b0, per, hi);
      chk("R9 running ratio held", per, 4);
      wr('0);
      idle(10);
      wr(EN | 32'h8);
      measure(1'b0, per, hi);
      chk("R9 new ratio after restart", per, 32);
      stop_all();
   endtask

   task automatic t_start();
      int per, hi;
      wr(EN | 32'h1);
      chk("R10 no strobe after write edge", int'(rise_n), 0);
      @(negedge clk);
      chk("R10 first strobe second edge", int'(rise_n), 1);
      measure(1'b0, per, hi);
      chk("R10 first period high", hi, 2);
      stop_all();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(3);
      t_reset();
      rst_n = 1'b1;
      idle(2);
      chk("R7 disabled no strobe", int'(rise_n), 0);
      t_onehot();
      t_div2_div1();
      t_div1024();
      t_priority();
      t_readback();
      t_stop_midhigh();
      t_auto_off();
      t_change_running();
      t_start();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule